// File: doc/BRIEF.md
# Power Supply Supervisory Sequencer

This block supervises a converter whose output voltage follows an 8-bit reference duty word. It advances only on a tick strobe. Each tick it reads a shutdown request, a 2-bit voltage select and four sampled words: input voltage, output voltage, output current and temperature. From these it moves through six states: off, start-up delay, soft ramp, regulation, over-temperature warning and latched fault.

While the state machine is ramping, it steps the duty word toward one of four preset targets. It enables the power stage driver and reports power-good, an alarm and a latched fault. A short on the output causes a restart. The number of restarts is limited. When no restarts remain, the block stays in the fault state until the user asserts shutdown.

All thresholds, the delay length, the retry limit and the four targets are parameters. Every comparison is unsigned.

Top module: `psu_supervisor`

## Requirements
- R1: After reset, and at all times in the off state, duty is 0 and drv_en, pgood, alarm and fault are all low.
- R2: The off state is left on a tick only when shdn_n is high and vin is strictly above UVLO_TH. Equality with the threshold, or any lower value, keeps the block off.
- R3: The start-up delay lasts exactly DELAY_TICKS ticks with the driver off. The tick that ends the delay enables the driver with duty still 0.
- R4: In the ramp state, each tick moves duty one step toward the selected target, upward or downward. vsel values 0, 1, 2 and 3 select TARGET0, TARGET1, TARGET2 and TARGET3. The target is read live on every tick. On the first tick that finds duty equal to the target, the block enters regulation, and pgood rises.
- R5: When regulating, a tick that finds the selected target different from duty returns the block to the ramp state. pgood goes low and duty is unchanged on that tick.
- R6: On a tick, shdn_n low or vin below UVLO_TH forces the off state from the delay, ramp, regulation and warning states. This clears duty and drops the driver, and it restarts the delay count on the next start.
- R7: When regulating, temp above TEMP_HI moves the block to the warning state. The warning state returns to regulation only when temp is below TEMP_LO. Throughout the warning state the driver stays on, duty is held and pgood stays high.
- R8: alarm is high in the warning state. In regulation alarm is high exactly when iout is above OC_TH. alarm is low in every other state.
- R9: A short is detected when vout is below the selected target shifted right by one. In regulation or warning, a short with a nonzero retry count moves the block to the off state and decrements the count. The block then restarts by itself on the following ticks.
- R10: A short found with a retry count of zero enters the fault state. fault is high only there, and in the fault state the driver is off and duty is 0.
- R11: The fault state is left only on a tick with shdn_n low. Undervoltage has no effect on it. The retry count is restored to RETRY_MAX only on ticks spent in the off state with shdn_n low.
- R12: When several conditions hold on the same tick, a short wins over over-temperature, and over-temperature wins over a target change. Shutdown and undervoltage win over all of them.
- R13: Without a tick the state, duty word and counters hold whatever the inputs do. An unused state encoding returns to the off state on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe that advances the supervisor |
| shdn_n | input | 1 | Active-low shutdown request |
| vsel | input | 2 | Preset target select |
| vin | input | SENSE_W | Sampled input voltage |
| vout | input | SENSE_W | Sampled output voltage, in duty units |
| iout | input | SENSE_W | Sampled output current |
| temp | input | SENSE_W | Sampled temperature |
| duty | output | DUTY_W | Reference duty word |
| drv_en | output | 1 | Power stage driver enable |
| pgood | output | 1 | Output in regulation |
| alarm | output | 1 | Over-current or over-temperature indicator |
| fault | output | 1 | Latched fault |

## Verification
Every state change, duty step and count update lands on the clock edge that samples a high tick. Because drv_en, pgood and fault decode the state register, they are due one edge after the tick. alarm also depends combinationally on iout, so it is due in that same cycle. The bench changes inputs and raises tick on a falling edge. It checks on the following falling edge, after exactly the number of ticks each requirement counts. These counts include 100 delay ticks, one tick per duty step and one extra tick to enter regulation. A vector table walks the temperature hysteresis and current alarm edges. Directed sequences cover the ramp, the restarts and the fault.

// File: rtl/psu_supervisor.sv
module psu_supervisor #(
  parameter int SENSE_W     = 10,
  parameter int DUTY_W      = 8,
  parameter int DELAY_TICKS = 100,
  parameter int RETRY_MAX   = 2,
  parameter logic [SENSE_W-1:0] UVLO_TH = 10'd200,
  parameter logic [SENSE_W-1:0] TEMP_HI = 10'd600,
  parameter logic [SENSE_W-1:0] TEMP_LO = 10'd500,
  parameter logic [SENSE_W-1:0] OC_TH   = 10'd700,
  parameter logic [DUTY_W-1:0]  TARGET0 = 8'd40,
  parameter logic [DUTY_W-1:0]  TARGET1 = 8'd60,
  parameter logic [DUTY_W-1:0]  TARGET2 = 8'd80,
  parameter logic [DUTY_W-1:0]  TARGET3 = 8'd100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               shdn_n,
  input  logic [1:0]         vsel,
  input  logic [SENSE_W-1:0] vin,
  input  logic [SENSE_W-1:0] vout,
  input  logic [SENSE_W-1:0] iout,
  input  logic [SENSE_W-1:0] temp,
  output logic [DUTY_W-1:0]  duty,
  output logic               drv_en,
  output logic               pgood,
  output logic               alarm,
  output logic               fault
);

  localparam int CW = $clog2(DELAY_TICKS + 1) < 1 ? 1 : $clog2(DELAY_TICKS + 1);
  localparam int RW = $clog2(RETRY_MAX + 1) < 1 ? 1 : $clog2(RETRY_MAX + 1);

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_WARN  = 3'd4,
    ST_LATCH = 3'd5
  } st_t;

  st_t              st, st_nx;
  logic [DUTY_W-1:0] duty_q, duty_nx, tgt;
  logic [CW-1:0]     cnt_q, cnt_nx;
  logic [RW-1:0]     retry_q, retry_nx;
  logic [SENSE_W-1:0] half_tgt;

  always_comb begin
    case (vsel)
      2'd0:    tgt = TARGET0;
      2'd1:    tgt = TARGET1;
      2'd2:    tgt = TARGET2;
      default: tgt = TARGET3;
    endcase
  end

  assign half_tgt = SENSE_W'(tgt >> 1);

  wire uv_low  = vin < UVLO_TH;
  wire vin_ok  = vin > UVLO_TH;
  wire hot     = temp > TEMP_HI;
  wire cool    = temp < TEMP_LO;
  wire over_i  = iout > OC_TH;
  wire shorted = vout < half_tgt;

  always_comb begin
    st_nx    = st;
    duty_nx  = duty_q;
    cnt_nx   = cnt_q;
    retry_nx = retry_q;
    if (tick) begin
      case (st)
        ST_OFF: begin
          duty_nx = '0;
          if (!shdn_n) retry_nx = RW'(RETRY_MAX);
          else if (vin_ok) begin
            st_nx  = ST_WAIT;
            cnt_nx = CW'(DELAY_TICKS);
          end
        end
        ST_WAIT: begin
          if (cnt_q <= CW'(1)) st_nx = ST_RAMP;
          else cnt_nx = cnt_q - CW'(1);
        end
        ST_RAMP: begin
          if (duty_q == tgt)     st_nx = ST_RUN;
          else if (duty_q < tgt) duty_nx = duty_q + DUTY_W'(1);
          else                   duty_nx = duty_q - DUTY_W'(1);
        end
        ST_RUN, ST_WARN: begin
          if (st == ST_RUN) begin
            if (duty_q != tgt) st_nx = ST_RAMP;
            if (hot)           st_nx = ST_WARN;
          end else if (cool) begin
            st_nx = ST_RUN;
          end
          if (shorted) begin
            duty_nx = '0;
            if (retry_q != '0) begin
              st_nx    = ST_OFF;
              retry_nx = retry_q - RW'(1);
            end else begin
              st_nx = ST_LATCH;
            end
          end
        end
        ST_LATCH: begin
          duty_nx = '0;
          if (!shdn_n) st_nx = ST_OFF;
        end
        default: begin
          st_nx   = ST_OFF;
          duty_nx = '0;
        end
      endcase
      if (st != ST_OFF && st != ST_LATCH && (!shdn_n || uv_low)) begin
        st_nx    = ST_OFF;
        duty_nx  = '0;
        retry_nx = retry_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OFF;
      duty_q  <= '0;
      cnt_q   <= '0;
      retry_q <= RW'(RETRY_MAX);
    end else begin
      st      <= st_nx;
      duty_q  <= duty_nx;
      cnt_q   <= cnt_nx;
      retry_q <= retry_nx;
    end
  end

  assign duty   = duty_q;
  assign drv_en = (st == ST_RAMP) || (st == ST_RUN) || (st == ST_WARN);
  assign pgood  = (st == ST_RUN) || (st == ST_WARN);
  assign alarm  = (st == ST_WARN) || ((st == ST_RUN) && over_i);
  assign fault  = (st == ST_LATCH);

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(st) && $stable(duty_q) && $stable(retry_q)); // R13

  AST_RAMP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st == ST_RAMP) |=> (duty_q == $past(duty_q)) || (duty_q == $past(duty_q) + DUTY_W'(1))
                               || (duty_q == $past(duty_q) - DUTY_W'(1)) || (duty_q == '0)); // R4

  AST_SHDN_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !shdn_n) |=> (st == ST_OFF) && (duty_q == '0)); // R6

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LATCH && !(tick && !shdn_n)) |=> (st == ST_LATCH)); // R11

  AST_RETRY_REFILL_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_q > $past(retry_q)) |-> $past(st == ST_OFF && !shdn_n && tick)); // R11

  AST_LATCH_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(retry_q) == '0)); // R10

  AST_WARN_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WARN && $past(st == ST_WARN)) |-> $stable(duty_q)); // R7

endmodule

// File: tb/psu_supervisor_bench.sv
module psu_supervisor_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       shdn_n = 1'b0;
  logic [1:0] vsel = 2'd0;
  logic [9:0] vin = 10'd0, vout = 10'd0, iout = 10'd100, temp = 10'd300;
  logic [7:0] duty;
  logic       drv_en, pgood, alarm, fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psu_supervisor u_psu_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .shdn_n(shdn_n), .vsel(vsel),
    .vin(vin), .vout(vout), .iout(iout), .temp(temp),
    .duty(duty), .drv_en(drv_en), .pgood(pgood), .alarm(alarm), .fault(fault)
  );

  // temp[21:12], iout[11:2], expected alarm[1], expected pgood[0]
  localparam logic [21:0] VEC [9] = '{
    {10'd300, 10'd100, 1'b0, 1'b1},
    {10'd300, 10'd800, 1'b1, 1'b1},
    {10'd300, 10'd700, 1'b0, 1'b1},
    {10'd601, 10'd100, 1'b1, 1'b1},
    {10'd550, 10'd100, 1'b1, 1'b1},
    {10'd500, 10'd100, 1'b1, 1'b1},
    {10'd499, 10'd100, 1'b0, 1'b1},
    {10'd600, 10'd100, 1'b0, 1'b1},
    {10'd300, 10'd800, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  // off -> delay (1) -> 100 delay ticks -> 40 ramp steps -> regulation (1)
  task automatic bring_up(input string tag);
    step(142);
    chk(tag, pgood, 1);
    chk(tag, duty, 40);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 duty", duty, 0);
    chk("R1 drv_en", drv_en, 0);
    chk("R1 pgood", pgood, 0);
    chk("R1 fault", fault, 0);
    chk("R1 alarm", alarm, 0);

    shdn_n = 1'b1; vin = 10'd200; vout = 10'd40;
    step(150);
    chk("R2 vin at threshold stays off", drv_en, 0);
    chk("R2 duty off", duty, 0);

    vin = 10'd300;
    step(1);
    step(99);
    chk("R3 delay driver off", drv_en, 0);
    step(1);
    chk("R3 delay end driver on", drv_en, 1);
    chk("R3 delay end duty", duty, 0);
    step(40);
    chk("R4 ramp duty", duty, 40);
    chk("R4 ramp pgood low", pgood, 0);
    step(1);
    chk("R4 regulation pgood", pgood, 1);

    for (int i = 0; i < 9; i++) begin
      temp = VEC[i][21:12];
      iout = VEC[i][11:2];
      step(1);
      chk($sformatf("R7 R8 vector %0d alarm", i), alarm, int'(VEC[i][1]));
      chk($sformatf("R7 vector %0d pgood", i), pgood, int'(VEC[i][0]));
      chk($sformatf("R7 vector %0d duty", i), duty, 40);
    end
    iout = 10'd100; temp = 10'd300;
    step(1);

    vsel = 2'd3;
    repeat (10) @(negedge clk);
    chk("R13 no tick pgood", pgood, 1);
    chk("R13 no tick duty", duty, 40);
    vsel = 2'd0;

    vsel = 2'd1;
    step(1);
    chk("R5 retarget pgood", pgood, 0);
    chk("R5 retarget duty", duty, 40);
    step(20);
    chk("R4 ramp up duty", duty, 60);
    vout = 10'd60;
    step(1);
    chk("R4 ramp up done", pgood, 1);
    vsel = 2'd2;
    step(6);
    chk("R4 toward 80", duty, 65);
    vsel = 2'd0;
    step(1);
    chk("R4 live retarget down", duty, 64);
    step(24);
    chk("R4 ramp down duty", duty, 40);
    vout = 10'd40;
    step(1);
    chk("R4 ramp down done", pgood, 1);

    vsel = 2'd1; temp = 10'd700;
    step(1);
    chk("R12 temp over retarget alarm", alarm, 1);
    chk("R12 temp over retarget duty", duty, 40);
    vsel = 2'd0; temp = 10'd300;
    step(1);
    chk("R7 cool back", alarm, 0);

    vout = 10'd20;
    step(1);
    chk("R9 half target not short", pgood, 1);
    vout = 10'd19; temp = 10'd700;
    step(1);
    chk("R12 short over temp pgood", pgood, 0);
    chk("R9 short duty", duty, 0);
    chk("R9 short fault", fault, 0);
    vout = 10'd40; temp = 10'd300;
    bring_up("R9 auto restart 1");
    vout = 10'd19;
    step(1);
    chk("R9 second short fault", fault, 0);
    vout = 10'd40;
    bring_up("R9 auto restart 2");
    vout = 10'd19;
    step(1);
    chk("R10 fault set", fault, 1);
    chk("R10 fault driver", drv_en, 0);
    chk("R10 fault duty", duty, 0);
    chk("R10 fault pgood", pgood, 0);

    vin = 10'd100;
    step(5);
    chk("R11 undervoltage ignored in fault", fault, 1);
    vin = 10'd300;
    step(3);
    chk("R11 fault held", fault, 1);
    shdn_n = 1'b0;
    step(1);
    chk("R11 shutdown clears fault", fault, 0);
    step(1);
    shdn_n = 1'b1; vout = 10'd40;
    bring_up("R11 restart after clear");
    vout = 10'd19;
    step(1);
    chk("R11 retry refilled", fault, 0);
    vout = 10'd40;
    bring_up("R11 restart after refill");

    shdn_n = 1'b0;
    step(1);
    chk("R6 shutdown pgood", pgood, 0);
    chk("R6 shutdown duty", duty, 0);
    chk("R6 shutdown drv", drv_en, 0);
    shdn_n = 1'b1;
    bring_up("R6 restart");
    vin = 10'd199;
    step(1);
    chk("R6 undervoltage drv", drv_en, 0);
    chk("R6 undervoltage duty", duty, 0);
    vin = 10'd300;
    step(51);
    shdn_n = 1'b0;
    step(1);
    shdn_n = 1'b1;
    step(1);
    step(99);
    chk("R6 delay restarted", drv_en, 0);
    step(1);
    chk("R3 delay full length again", drv_en, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule